// File: doc/BRIEF.md
# Card Host Interrupt and Clock Control

This block is the register-level control core of a memory-card host controller. A CPU reads and writes a bank of sixteen word-addressed registers: a clock start/stop control, a status word, the transfer configuration (clock rate, command configuration, timeouts, block length and block count, command index and argument), an interrupt mask and an interrupt request word. The FIFO and command engines around it report events as one-cycle pulses on a request-set vector. The block merges these requests into one CPU interrupt and two DMA request lines.

When the configuration word enables DMA, the receive-FIFO and transmit-FIFO requests are no longer sent to the CPU interrupt. They drive the two DMA request lines instead. A clock-stop command clears the clock-enabled status, raises the clock-off request and emits a one-cycle transfer-abort pulse toward the data path. The card protocol, the FIFOs and response handling live outside this block.

Top module: `card_irq_ctrl`

## Requirements
- R1: After reset, all registers read 0, except the command index at offset 11, which reads 0x0040. `cpuIrq`, `rxDmaReq`, `txDmaReq` and `xferAbort` are all low.
- R2: `cpuIrq` is high when at least one request bit is 1 and its mask bit (mask register, offset 9) is 0. A mask bit of 1 suppresses its source.
- R3: When bit 7 of the configuration word (offset 3) is 1, request bit 5 (receive FIFO) and request bit 6 (transmit FIFO) are excluded from `cpuIrq`. Request bit 5 then drives `rxDmaReq` and request bit 6 drives `txDmaReq`. While bit 7 is 0, both DMA lines stay low.
- R4: Writing offset 0 with bit 1 set (start) makes status bit 8 (offset 1) read 1 and clears request bit 4 (clock off).
- R5: Writing offset 0 with bit 0 set (stop) clears status bit 8, sets request bit 4 and pulses `xferAbort` for one cycle. If bits 0 and 1 are both set in the same write, the stop wins.
- R6: Writes are truncated to the stored width and read back as follows: clock rate (offset 2) 3 bits; configuration (offset 3) masked with 0x3DFF; response timeout (offset 4) 7 bits; read timeout (offset 5) 16 bits; block length (offset 6) 12 bits; block count (offset 7) 16 bits; mask (offset 9) 13 bits.
- R7: The command index (offset 11) stores 6 bits. Reads return the index with bit 6 forced to 1.
- R8: The 32-bit argument is written as an upper half (offset 12) and a lower half (offset 13). Each half reads back at its own offset, and a write to one half leaves the other unchanged.
- R9: Offset 15 reads the block count. Offsets 0, 8 and 14 read 0.
- R10: The request word (offset 10) reads the pending bits. Writing it clears every bit written as 1. An event pulse on `evtSet` in the same cycle as a clear of the same bit leaves that bit set.
- R11: Register state changes on the clock edge that captures the write or event pulse. `cpuIrq`, `rxDmaReq` and `txDmaReq` follow one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Word offset for read and write |
| wrData | input | 16 | Write data |
| evtSet | input | 13 | One-cycle pulses that set request bits |
| rdData | output | 16 | Read data for `addr` (combinational) |
| cpuIrq | output | 1 | CPU interrupt request |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |
| xferAbort | output | 1 | One-cycle pulse after a clock-stop write |

## Verification
The hardest conditions to reach are collisions inside a single cycle. One is an event pulse landing on the same edge as a write that clears that bit. Another is a write that asks for start and stop together. A third is enabling DMA while unmasked FIFO requests are already pending.

The bench drives the request-word write and the matching `evtSet` pulse in the same cycle. It issues the combined start/stop value after a plain start. It switches the DMA-enable bit only after first clearing every non-FIFO request, so that the drop of `cpuIrq` can only come from the steering. A behavioural model checks outputs and read data every cycle against those orderings.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;
  parameter int DATA_W   = 16;
  parameter int ADDR_W   = 4;
  parameter int IRQ_W    = 13;
  parameter int RATE_W   = 3;
  parameter int RESPTO_W = 7;
  parameter int RDTO_W   = 16;
  parameter int BLKLEN_W = 12;
  parameter int BLKCNT_W = 16;
  parameter int CMD_W    = 6;
  parameter int CFG_W    = 14;

  localparam logic [CFG_W-1:0] CFG_KEEP = CFG_W'(14'h3dff);

  localparam int CLK_STOP_BIT  = 0;
  localparam int CLK_START_BIT = 1;
  localparam int STAT_CLK_BIT  = 8;
  localparam int DMA_EN_BIT    = 7;
  localparam int REQ_CLKOFF    = 4;
  localparam int REQ_RX        = 5;
  localparam int REQ_TX        = 6;
  localparam int CMD_FLAG_BIT  = 6;

  typedef enum logic [ADDR_W-1:0] {
    OFS_CLKCTL  = 4'd0,
    OFS_STATUS  = 4'd1,
    OFS_RATE    = 4'd2,
    OFS_CFG     = 4'd3,
    OFS_RESPTO  = 4'd4,
    OFS_RDTO    = 4'd5,
    OFS_BLKLEN  = 4'd6,
    OFS_BLKCNT  = 4'd7,
    OFS_PARTBUF = 4'd8,
    OFS_MASK    = 4'd9,
    OFS_REQ     = 4'd10,
    OFS_CMD     = 4'd11,
    OFS_ARGHI   = 4'd12,
    OFS_ARGLO   = 4'd13,
    OFS_RDWAIT  = 4'd14,
    OFS_BLKREM  = 4'd15
  } regOfs_e;

  typedef struct packed {
    logic clkStart;
    logic clkStop;
    logic ldRate;
    logic ldCfg;
    logic ldRespTo;
    logic ldRdTo;
    logic ldBlkLen;
    logic ldBlkCnt;
    logic ldMask;
    logic clrReq;
    logic ldCmd;
    logic ldArgHi;
    logic ldArgLo;
  } ctlStrobe_t;
endpackage

// File: rtl/card_irq_decode.sv
module card_irq_decode
  import card_irq_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        clkBits,
  output ctlStrobe_t        stb
);
  always_comb begin
    stb = '0;
    if (wrEn) begin
      case (addr)
        OFS_CLKCTL: begin
          stb.clkStart = clkBits[CLK_START_BIT];
          stb.clkStop  = clkBits[CLK_STOP_BIT];
        end
        OFS_RATE:   stb.ldRate   = 1'b1;
        OFS_CFG:    stb.ldCfg    = 1'b1;
        OFS_RESPTO: stb.ldRespTo = 1'b1;
        OFS_RDTO:   stb.ldRdTo   = 1'b1;
        OFS_BLKLEN: stb.ldBlkLen = 1'b1;
        OFS_BLKCNT: stb.ldBlkCnt = 1'b1;
        OFS_MASK:   stb.ldMask   = 1'b1;
        OFS_REQ:    stb.clrReq   = 1'b1;
        OFS_CMD:    stb.ldCmd    = 1'b1;
        OFS_ARGHI:  stb.ldArgHi  = 1'b1;
        OFS_ARGLO:  stb.ldArgLo  = 1'b1;
        default:    stb = '0;
      endcase
    end
  end
endmodule

// File: rtl/card_irq_regs.sv
module card_irq_regs
  import card_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IRQ_W-1:0]  evtSet,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [IRQ_W-1:0]  reqBits,
  output logic [IRQ_W-1:0]  maskBits,
  output logic              dmaEn,
  output logic              clkEnabled,
  output logic              xferAbort
);
  logic [RATE_W-1:0]   rate;
  logic [CFG_W-1:0]    cfg;
  logic [RESPTO_W-1:0] respTo;
  logic [RDTO_W-1:0]   rdTo;
  logic [BLKLEN_W-1:0] blkLen;
  logic [BLKCNT_W-1:0] blkCnt;
  logic [CMD_W-1:0]    cmdIdx;
  logic [DATA_W-1:0]   argHi;
  logic [DATA_W-1:0]   argLo;
  logic [IRQ_W-1:0]    mask;
  logic [IRQ_W-1:0]    req;
  logic [IRQ_W-1:0]    reqClr;
  logic [IRQ_W-1:0]    reqSet;
  logic [IRQ_W-1:0]    reqNext;
  logic                clkEn;
  logic                abortQ;

  // Clears first, then sets: a stop or an event pulse beats any clear
  always_comb begin
    reqClr = stb.clrReq ? wrData[IRQ_W-1:0] : '0;
    if (stb.clkStart) reqClr[REQ_CLKOFF] = 1'b1;
    reqSet = evtSet;
    if (stb.clkStop) reqSet[REQ_CLKOFF] = 1'b1;
    reqNext = (req & ~reqClr) | reqSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rate   <= '0;
      cfg    <= '0;
      respTo <= '0;
      rdTo   <= '0;
      blkLen <= '0;
      blkCnt <= '0;
      cmdIdx <= '0;
      argHi  <= '0;
      argLo  <= '0;
      mask   <= '0;
      req    <= '0;
      clkEn  <= 1'b0;
      abortQ <= 1'b0;
    end else begin
      if (stb.ldRate)   rate   <= wrData[RATE_W-1:0];
      if (stb.ldCfg)    cfg    <= wrData[CFG_W-1:0] & CFG_KEEP;
      if (stb.ldRespTo) respTo <= wrData[RESPTO_W-1:0];
      if (stb.ldRdTo)   rdTo   <= wrData[RDTO_W-1:0];
      if (stb.ldBlkLen) blkLen <= wrData[BLKLEN_W-1:0];
      if (stb.ldBlkCnt) blkCnt <= wrData[BLKCNT_W-1:0];
      if (stb.ldCmd)    cmdIdx <= wrData[CMD_W-1:0];
      if (stb.ldArgHi)  argHi  <= wrData;
      if (stb.ldArgLo)  argLo  <= wrData;
      if (stb.ldMask)   mask   <= wrData[IRQ_W-1:0];
      req <= reqNext;
      if (stb.clkStop)       clkEn <= 1'b0;
      else if (stb.clkStart) clkEn <= 1'b1;
      abortQ <= stb.clkStop;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      OFS_STATUS: rdData[STAT_CLK_BIT] = clkEn;
      OFS_RATE:   rdData = DATA_W'(rate);
      OFS_CFG:    rdData = DATA_W'(cfg);
      OFS_RESPTO: rdData = DATA_W'(respTo);
      OFS_RDTO:   rdData = DATA_W'(rdTo);
      OFS_BLKLEN: rdData = DATA_W'(blkLen);
      OFS_BLKCNT: rdData = DATA_W'(blkCnt);
      OFS_MASK:   rdData = DATA_W'(mask);
      OFS_REQ:    rdData = DATA_W'(req);
      OFS_CMD: begin
        rdData = DATA_W'(cmdIdx);
        rdData[CMD_FLAG_BIT] = 1'b1;
      end
      OFS_ARGHI:  rdData = argHi;
      OFS_ARGLO:  rdData = argLo;
      OFS_BLKREM: rdData = DATA_W'(blkCnt);
      default:    rdData = '0;
    endcase
  end

  assign reqBits    = req;
  assign maskBits   = mask;
  assign dmaEn      = cfg[DMA_EN_BIT];
  assign clkEnabled = clkEn;
  assign xferAbort  = abortQ;
endmodule

// File: rtl/card_irq_route.sv
module card_irq_route
  import card_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [IRQ_W-1:0] reqBits,
  input  logic [IRQ_W-1:0] maskBits,
  input  logic             dmaEn,
  output logic             cpuIrq,
  output logic             rxDmaReq,
  output logic             txDmaReq
);
  logic [IRQ_W-1:0] pend;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_src
    localparam bit IS_FIFO = (i == REQ_RX) || (i == REQ_TX);
    if (IS_FIFO) begin : g_fifo
      assign pend[i] = reqBits[i] & ~maskBits[i] & ~dmaEn;
    end else begin : g_plain
      assign pend[i] = reqBits[i] & ~maskBits[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuIrq   <= 1'b0;
      rxDmaReq <= 1'b0;
      txDmaReq <= 1'b0;
    end else begin
      cpuIrq   <= |pend;
      rxDmaReq <= dmaEn & reqBits[REQ_RX];
      txDmaReq <= dmaEn & reqBits[REQ_TX];
    end
  end
endmodule

// File: rtl/card_irq_ctrl.sv
module card_irq_ctrl
  import card_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IRQ_W-1:0]  evtSet,
  output logic [DATA_W-1:0] rdData,
  output logic              cpuIrq,
  output logic              rxDmaReq,
  output logic              txDmaReq,
  output logic              xferAbort
);
  ctlStrobe_t       stb;
  logic [IRQ_W-1:0] reqBits;
  logic [IRQ_W-1:0] maskBits;
  logic             dmaEn;
  logic             clkEnabled;

  card_irq_decode u_decode (
    .wrEn    (wrEn),
    .addr    (addr),
    .clkBits (wrData[1:0]),
    .stb     (stb)
  );

  card_irq_regs u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .evtSet     (evtSet),
    .rdAddr     (addr),
    .rdData     (rdData),
    .reqBits    (reqBits),
    .maskBits   (maskBits),
    .dmaEn      (dmaEn),
    .clkEnabled (clkEnabled),
    .xferAbort  (xferAbort)
  );

  card_irq_route u_route (
    .clk      (clk),
    .rstN     (rstN),
    .reqBits  (reqBits),
    .maskBits (maskBits),
    .dmaEn    (dmaEn),
    .cpuIrq   (cpuIrq),
    .rxDmaReq (rxDmaReq),
    .txDmaReq (txDmaReq)
  );
endmodule

// File: rtl/card_irq_chk.sv
module card_irq_chk
  import card_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [IRQ_W-1:0]  evtSet,
  input logic [IRQ_W-1:0]  reqBits,
  input logic [IRQ_W-1:0]  maskBits,
  input logic              dmaEn,
  input logic              clkEnabled,
  input logic              cpuIrq,
  input logic              rxDmaReq,
  input logic              txDmaReq,
  input logic              xferAbort
);
  localparam logic [IRQ_W-1:0] FIFO_REQS = IRQ_W'((1 << REQ_RX) | (1 << REQ_TX));

  // R2
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> $past((reqBits & ~maskBits) != '0));

  // R3
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxDmaReq || txDmaReq) |-> $past(dmaEn));

  // R3
  dma_steer_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dmaEn) && $past((reqBits & ~maskBits & ~FIFO_REQS) == '0)) |-> !cpuIrq);

  // R5
  clk_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_CLKCTL && wrData[CLK_STOP_BIT])
      |=> (!clkEnabled && reqBits[REQ_CLKOFF] && xferAbort));

  // R4
  clk_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_CLKCTL && wrData[CLK_START_BIT] && !wrData[CLK_STOP_BIT])
      |=> clkEnabled);

  // R10
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtSet != '0) |=> ((reqBits & $past(evtSet)) == $past(evtSet)));
endmodule

bind card_irq_ctrl card_irq_chk chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .addr       (addr),
  .wrData     (wrData),
  .evtSet     (evtSet),
  .reqBits    (reqBits),
  .maskBits   (maskBits),
  .dmaEn      (dmaEn),
  .clkEnabled (clkEnabled),
  .cpuIrq     (cpuIrq),
  .rxDmaReq   (rxDmaReq),
  .txDmaReq   (txDmaReq),
  .xferAbort  (xferAbort)
);

// File: tb/card_irq_ctrl_test.sv
module card_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [12:0] evtSet = '0;
  logic [15:0] rdData;
  logic        cpuIrq, rxDmaReq, txDmaReq, xferAbort;

  int checks = 0;
  int errors = 0;

  // reference state
  int mRate, mCfg, mRespTo, mRdTo, mBlkLen, mBlkCnt, mCmd, mArgHi, mArgLo, mMask, mReq;
  bit mClkEn, mIrq, mRx, mTx, mAbort;

  always #2 clk = ~clk;

  card_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .evtSet(evtSet), .rdData(rdData), .cpuIrq(cpuIrq), .rxDmaReq(rxDmaReq),
    .txDmaReq(txDmaReq), .xferAbort(xferAbort)
  );

  function automatic int modelRead(int a);
    case (a)
      1:  return mClkEn ? 32'h100 : 0;
      2:  return mRate;
      3:  return mCfg;
      4:  return mRespTo;
      5:  return mRdTo;
      6:  return mBlkLen;
      7:  return mBlkCnt;
      9:  return mMask;
      10: return mReq;
      11: return mCmd | 32'h40;
      12: return mArgHi;
      13: return mArgLo;
      15: return mBlkCnt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mRate = 0; mCfg = 0; mRespTo = 0; mRdTo = 0; mBlkLen = 0; mBlkCnt = 0;
      mCmd = 0; mArgHi = 0; mArgLo = 0; mMask = 0; mReq = 0; mClkEn = 0;
      mIrq = 0; mRx = 0; mTx = 0; mAbort = 0;
    end else begin
      int eff, d, clr, setb;
      bit dma;
      dma  = (mCfg & 32'h80) != 0;
      eff  = mMask | (dma ? 32'h60 : 0);
      mIrq = (mReq & ~eff & 32'h1fff) != 0;
      mRx  = dma && ((mReq & 32'h20) != 0);
      mTx  = dma && ((mReq & 32'h40) != 0);
      d    = int'(wrData);
      mAbort = wrEn && addr == 0 && d[0];
      clr = 0; setb = 0;
      if (wrEn) begin
        case (int'(addr))
          0: begin
            if (d[1]) begin mClkEn = 1; clr = 32'h10; end
            if (d[0]) begin mClkEn = 0; setb = 32'h10; end
          end
          2:  mRate   = d & 7;
          3:  mCfg    = d & 32'h3dff;
          4:  mRespTo = d & 32'h7f;
          5:  mRdTo   = d & 32'hffff;
          6:  mBlkLen = d & 32'hfff;
          7:  mBlkCnt = d & 32'hffff;
          9:  mMask   = d & 32'h1fff;
          10: clr     = d & 32'h1fff;
          11: mCmd    = d & 32'h3f;
          12: mArgHi  = d & 32'hffff;
          13: mArgLo  = d & 32'hffff;
          default: ;
        endcase
      end
      mReq = ((mReq & ~clr) | setb | int'(evtSet)) & 32'h1fff;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN) begin
        chk("R2 cpuIrq per-cycle", int'(cpuIrq), int'(mIrq));
        chk("R3 rxDmaReq per-cycle", int'(rxDmaReq), int'(mRx));
        chk("R3 txDmaReq per-cycle", int'(txDmaReq), int'(mTx));
        chk("R5 xferAbort per-cycle", int'(xferAbort), int'(mAbort));
        chk("R6 rdData per-cycle", int'(rdData), modelRead(int'(addr)));
      end
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; addr = 4'(a); wrData = 16'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulse(int bits);
    @(negedge clk);
    evtSet = 13'(bits);
    @(negedge clk);
    evtSet = '0;
  endtask

  task automatic rd(int a, int exp, string tag);
    @(negedge clk);
    addr = 4'(a);
    #1;
    chk(tag, int'(rdData), exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(1, 0, "R1 status");
    rd(9, 0, "R1 mask");
    rd(10, 0, "R1 request");
    rd(11, 32'h40, "R1 cmd index");
    chk("R1 cpuIrq", int'(cpuIrq), 0);
    chk("R1 dma", int'({rxDmaReq, txDmaReq, xferAbort}), 0);
    // R6 truncation
    wr(2, 32'hffff);  rd(2, 7, "R6 rate");
    wr(3, 32'hffff);  rd(3, 32'h3dff, "R6 cfg");
    wr(4, 32'hffff);  rd(4, 32'h7f, "R6 resp timeout");
    wr(5, 32'hbeef);  rd(5, 32'hbeef, "R6 read timeout");
    wr(6, 32'hffff);  rd(6, 32'hfff, "R6 block length");
    wr(7, 32'h1234);  rd(7, 32'h1234, "R6 block count");
    wr(9, 32'hffff);  rd(9, 32'h1fff, "R6 mask");
    // R9
    rd(15, 32'h1234, "R9 blocks remaining");
    rd(0, 0, "R9 clock ctl reads 0");
    rd(8, 0, "R9 partial buffer reads 0");
    rd(14, 0, "R9 read wait reads 0");
    // R7
    wr(11, 32'hff);   rd(11, 32'h7f, "R7 cmd index");
    wr(11, 32'h05);   rd(11, 32'h45, "R7 cmd index small");
    // R8
    wr(12, 32'habcd); wr(13, 32'h1234);
    rd(12, 32'habcd, "R8 arg high");
    wr(13, 32'h5678);
    rd(12, 32'habcd, "R8 arg high kept");
    rd(13, 32'h5678, "R8 arg low");
    // R2 and R11
    wr(3, 0); wr(9, 0);
    pulse(32'h4);
    chk("R11 irq one cycle late", int'(cpuIrq), 0);
    @(negedge clk);
    chk("R2 irq on unmasked", int'(cpuIrq), 1);
    wr(9, 32'h4);
    @(negedge clk);
    chk("R2 masked source", int'(cpuIrq), 0);
    wr(9, 0);
    // R10 clear and priority
    wr(10, 32'h4);    rd(10, 0, "R10 write-one clear");
    @(negedge clk);
    wrEn = 1'b1; addr = 4'd10; wrData = 16'h8; evtSet = 13'h8;
    @(negedge clk);
    wrEn = 1'b0; evtSet = '0;
    rd(10, 32'h8, "R10 event beats clear");
    wr(10, 32'h1fff);
    // R3 DMA steering
    pulse(32'h20);
    @(negedge clk);
    chk("R3 rx to cpu when dma off", int'(cpuIrq), 1);
    chk("R3 rx dma low when off", int'(rxDmaReq), 0);
    wr(3, 32'h80);
    @(negedge clk);
    chk("R3 rx steered off cpu", int'(cpuIrq), 0);
    chk("R3 rx dma high", int'(rxDmaReq), 1);
    pulse(32'h40);
    @(negedge clk);
    chk("R3 tx dma high", int'(txDmaReq), 1);
    chk("R3 cpu still quiet", int'(cpuIrq), 0);
    wr(10, 32'h60);
    // R4 start
    wr(0, 32'h2);
    chk("R5 no abort on start", int'(xferAbort), 0);
    rd(1, 32'h100, "R4 clock enabled");
    rd(10, 0, "R4 clock-off cleared");
    // R5 stop
    wr(0, 32'h1);
    chk("R5 abort pulse", int'(xferAbort), 1);
    rd(1, 0, "R5 clock disabled");
    rd(10, 32'h10, "R5 clock-off set");
    @(negedge clk);
    chk("R5 cpuIrq from clock-off", int'(cpuIrq), 1);
    wr(0, 32'h2);
    wr(0, 32'h3);
    rd(1, 0, "R5 stop wins status");
    rd(10, 32'h10, "R5 stop wins request");
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule